// File: doc/BRIEF.md
# Conversion Start Delay Controller

This block decides when a converter starts delivering results after a start request. Start and stop requests come from two places: single-cycle pulses raised by register writes, and a start pin whose edges are detected here. A 3-bit delay code picks how many modulator clock ticks must elapse between the start event and the first conversion. A 2-bit mode selection decides whether the register requests are honoured. The modulator clock reaches the block as a one-cycle enable, `mod_tick`, in the system clock domain.

A state machine with three states holds the run status. `ST_IDLE` means conversions are stopped. `ST_WAIT` counts modulator ticks down. `ST_RUN` means conversions are active. The transitions are:
- idle-to-wait on a start event;
- wait-to-run when the count has expired and a modulator tick arrives;
- wait-to-wait (re-arm) on a new start event;
- run-to-wait (restart) on a start event;
- any state to idle on a stop event.

When the stop and start events fall in the same cycle, the stop event is taken. The block drives three outputs:
- a run level;
- a one-cycle pulse marking the first conversion;
- a channel analog power-down request, which the standby selection controls while the block is stopped.

Top module: `conv_start_delay`

## Requirements
- R1: While and after reset, `run` and `first_conv` are 0 and the block is in `ST_IDLE`.
- R2: Delay codes 0 to 7 give 0, 4, 8, 16, 32, 128, 512 and 1024 modulator cycles. With delay D, `run` rises at the clock edge of the (D+1)-th `mod_tick` that follows the start-event cycle. A tick in the start-event cycle itself is not counted.
- R3: A start event while in `ST_WAIT` or `ST_RUN` restarts the delay. `run` is 0 from the next cycle, and the full delay runs again.
- R4: A stop event returns the block to `ST_IDLE`, with `run` at 0 from the next cycle. Conversions then stay off until a new start event.
- R5: With mode code 2'b10 (synchronized), `reg_start` and `reg_stop` have no effect. Only edges on the start pin act.
- R6: Mode codes 2'b00, 2'b01 and 2'b11 all behave as start/stop control. In these modes both the register pulses and the pin edges act.
- R7: A stop event during the `ST_WAIT` countdown cancels the pending start, and `run` does not rise.
- R8: With delay code 0, `run` rises on the first `mod_tick` after the start event.
- R9: When a start event and a stop event occur in the same cycle, the block goes to `ST_IDLE`.
- R10: `analog_pd` is 1 exactly when the block is in `ST_IDLE` and `standby_sel` is 1. It is 0 in `ST_WAIT` and `ST_RUN`.
- R11: `first_conv` is a one-cycle pulse. It is raised in the cycle in which `run` first becomes 1 after a wait.
- R12: A rising edge on `pin_start` is a start event and a falling edge is a stop event, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_tick | input | 1 | One-cycle enable, once per modulator clock |
| reg_start | input | 1 | Start pulse from a register write |
| reg_stop | input | 1 | Stop pulse from a register write |
| pin_start | input | 1 | Start pin level, already deglitched |
| mode_sel | input | 2 | Control mode: 2'b10 synchronized, all others start/stop |
| delay_code | input | 3 | Conversion start delay selection |
| standby_sel | input | 1 | 1: power down channel analog while stopped |
| run | output | 1 | Conversions active |
| first_conv | output | 1 | Pulse at the start of the first conversion |
| analog_pd | output | 1 | Channel analog power-down request |

## Verification
The bench measures the tick count to `run` for every delay code, under both continuous and sparse ticks. An off-by-one in the countdown, or a tick counted in the start cycle, would shift these counts. It restarts a running block and stops it mid-countdown. A design that ignored the restart would keep `run` high, and one that latched the pending start would raise `run` after a stop. It also drives simultaneous start and stop, and register pulses in synchronized and reserved modes. A wrong priority or a wrong mode decode would leave conversions running or fail to start them.

// File: rtl/csd_pkg.sv
package csd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_state_t;

    localparam logic [1:0] MODE_SYNC = 2'b10;

    // Modulator cycles for each delay code (non-uniform table).
    function automatic int unsigned delay_cycles(input logic [2:0] code);
        int unsigned v;
        if (code == 3'd0)
            v = 0;
        else if (code <= 3'd4)
            v = 32'd1 << (int'(code) + 1);
        else if (code == 3'd5)
            v = 128;
        else if (code == 3'd6)
            v = 512;
        else
            v = 1024;
        return v;
    endfunction

endpackage

// File: rtl/csd_event_decode.sv
module csd_event_decode
    import csd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       reg_start_i,
    input  logic       reg_stop_i,
    input  logic       pin_i,
    output logic       start_o,
    output logic       stop_o
);
    logic pin_q;
    logic pin_rise;
    logic pin_fall;
    logic reg_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_i;
    end

    assign pin_rise = pin_i & ~pin_q;
    assign pin_fall = ~pin_i & pin_q;
    // Reserved mode codes fall back to start/stop control.
    assign reg_ok   = (mode_i != MODE_SYNC);
    assign start_o  = pin_rise | (reg_ok & reg_start_i);
    assign stop_o   = pin_fall | (reg_ok & reg_stop_i);

    // R12: a pin edge always produces an event
    p_pin_edge_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_i != pin_q) |-> (start_o | stop_o));

endmodule

// File: rtl/csd_delay_counter.sv
module csd_delay_counter #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (dec_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R2: counter never goes up except by a load
    p_cnt_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/csd_fsm.sv
module csd_fsm
    import csd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_i,
    input  logic zero_i,
    input  logic standby_i,
    output logic load_o,
    output logic dec_o,
    output logic run_o,
    output logic first_o,
    output logic pd_o
);
    run_state_t state_q;
    run_state_t state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_i)       state_nx = ST_IDLE;
                else if (start_i) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (stop_i)                 state_nx = ST_IDLE;
                else if (start_i)           state_nx = ST_WAIT;
                else if (tick_i && zero_i)  state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (stop_i)       state_nx = ST_IDLE;
                else if (start_i) state_nx = ST_WAIT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_o   <= 1'b0;
            first_o <= 1'b0;
        end else begin
            run_o   <= (state_nx == ST_RUN);
            first_o <= (state_nx == ST_RUN) && (state_q != ST_RUN);
        end
    end

    assign load_o = start_i & ~stop_i;
    assign dec_o  = (state_q == ST_WAIT) & tick_i;
    assign pd_o   = (state_q == ST_IDLE) & standby_i;

    // R1: run reflects the state register
    p_run_matches_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run_o == (state_q == ST_RUN));
    // R11: first_conv is a single pulse that comes with run
    p_first_with_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |-> run_o);
    p_first_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |=> !first_o);
    // R2: run only rises on a modulator tick
    p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(tick_i));
    // R3: a start without stop drops run on the next cycle
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (!run_o && state_q == ST_WAIT));
    // R4, R7, R9: stop always returns to idle
    p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == ST_IDLE && !run_o));
    // R10: power-down only while stopped
    p_pd_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_o |-> !run_o);

endmodule

// File: rtl/conv_start_delay.sv
module conv_start_delay
    import csd_pkg::*;
#(
    parameter int unsigned MAX_DELAY = 1024,
    localparam int unsigned CNT_W    = $clog2(MAX_DELAY + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mod_tick,
    input  logic       reg_start,
    input  logic       reg_stop,
    input  logic       pin_start,
    input  logic [1:0] mode_sel,
    input  logic [2:0] delay_code,
    input  logic       standby_sel,
    output logic       run,
    output logic       first_conv,
    output logic       analog_pd
);
    logic             start_ev;
    logic             stop_ev;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_zero;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(delay_cycles(delay_code));

    csd_event_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_sel),
        .reg_start_i (reg_start),
        .reg_stop_i  (reg_stop),
        .pin_i       (pin_start),
        .start_o     (start_ev),
        .stop_o      (stop_ev)
    );

    csd_delay_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (load_val),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    csd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_ev),
        .stop_i    (stop_ev),
        .tick_i    (mod_tick),
        .zero_i    (cnt_zero),
        .standby_i (standby_sel),
        .load_o    (cnt_load),
        .dec_o     (cnt_dec),
        .run_o     (run),
        .first_o   (first_conv),
        .pd_o      (analog_pd)
    );

    // R9: simultaneous register start and stop in control mode ends idle
    p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_start && reg_stop && mode_sel != MODE_SYNC) |=> (!run && !first_conv));
    // R7: stop while a start is pending never produces a first conversion
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !first_conv);

endmodule

// File: tb/test_conv_start_delay.sv
module test_conv_start_delay;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_tick = 1'b0;
    logic       reg_start = 1'b0;
    logic       reg_stop = 1'b0;
    logic       pin_start = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [2:0] delay_code = 3'd0;
    logic       standby_sel = 1'b1;
    logic       run;
    logic       first_conv;
    logic       analog_pd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    conv_start_delay i_conv_start_delay (
        .clk (clk), .rst_n (rst_n), .mod_tick (mod_tick),
        .reg_start (reg_start), .reg_stop (reg_stop), .pin_start (pin_start),
        .mode_sel (mode_sel), .delay_code (delay_code), .standby_sel (standby_sel),
        .run (run), .first_conv (first_conv), .analog_pd (analog_pd)
    );

    function automatic int exp_delay(input logic [2:0] c);
        case (c)
            3'd0: return 0;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            3'd5: return 128;
            3'd6: return 512;
            default: return 1024;
        endcase
    endfunction

    // Behavioural expectation built from the requirements
    int m_state;
    int m_cnt;
    bit m_prev;
    bit m_first;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_cnt <= 0; m_prev <= 1'b0; m_first <= 1'b0;
        end else begin
            bit rs_ok, st, sp;
            rs_ok = (mode_sel != 2'b10);
            st = (pin_start && !m_prev) || (rs_ok && reg_start);
            sp = (!pin_start && m_prev) || (rs_ok && reg_stop);
            m_prev  <= pin_start;
            m_first <= 1'b0;
            if (sp) m_state <= 0;
            else if (st) begin
                m_state <= 1; m_cnt <= exp_delay(delay_code);
            end else if (m_state == 1 && mod_tick) begin
                if (m_cnt == 0) begin m_state <= 2; m_first <= 1'b1; end
                else m_cnt <= m_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(run == (m_state == 2), "model run R2 R3 R7", run, m_state == 2);
        chk(first_conv == m_first, "model first R11", first_conv, m_first);
        chk(analog_pd == (m_state == 0 && standby_sel), "model pd R10",
            analog_pd, m_state == 0 && standby_sel);
    endtask

    task automatic pulse_start();
        reg_start = 1'b1; step(); reg_start = 1'b0;
    endtask

    task automatic pulse_stop();
        reg_stop = 1'b1; step(); reg_stop = 1'b0;
    endtask

    task automatic measure(input logic [2:0] c, input string req);
        int n = 0;
        delay_code = c; mod_tick = 1'b1; mode_sel = 2'b00;
        pulse_start();
        while (!run && n < 3000) begin step(); n++; end
        chk(n == exp_delay(c) + 1, req, n, exp_delay(c) + 1);
        chk(first_conv == 1'b1, "R11 first at run rise", first_conv, 1);
        step();
        chk(first_conv == 1'b0, "R11 first one cycle", first_conv, 0);
        pulse_stop();
        chk(run == 1'b0, "R4 stop", run, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(run == 1'b0, "R1 run in reset", run, 0);
        chk(first_conv == 1'b0, "R1 first in reset", first_conv, 0);
        rst_n = 1'b1;
        step();
        chk(run == 1'b0, "R1 run after reset", run, 0);
        chk(analog_pd == 1'b1, "R10 pd idle standby", analog_pd, 1);

        // R2, R8: every delay code with a tick every cycle
        measure(3'd0, "R8 code0 delay");
        for (int c = 1; c < 8; c++) measure(3'(c), "R2 delay code");

        // R2: sparse ticks, code 1 needs 5 ticks
        begin
            int ticks = 0;
            delay_code = 3'd1; mod_tick = 1'b1;
            pulse_start();
            for (int k = 0; k < 60 && !run; k++) begin
                mod_tick = (k % 3 == 0);
                step();
                if (mod_tick) ticks++;
            end
            chk(ticks == 5, "R2 sparse ticks", ticks, 5);
            mod_tick = 1'b1;
            pulse_stop();
        end

        // R3: restart while running
        delay_code = 3'd2;
        pulse_start();
        repeat (9) step();
        chk(run == 1'b1, "R3 running before restart", run, 1);
        pulse_start();
        chk(run == 1'b0, "R3 restart drops run", run, 0);
        begin
            int n = 0;
            while (!run && n < 100) begin step(); n++; end
            chk(n == 9, "R3 restart reruns delay", n, 9);
        end
        pulse_stop();

        // R7: stop during countdown
        delay_code = 3'd7;
        pulse_start();
        repeat (100) step();
        chk(analog_pd == 1'b0, "R10 pd low while waiting", analog_pd, 0);
        pulse_stop();
        repeat (1100) step();
        chk(run == 1'b0, "R7 cancelled start", run, 0);

        // R9: start and stop together, from idle and from run
        delay_code = 3'd0;
        reg_start = 1'b1; reg_stop = 1'b1; step(); reg_start = 1'b0; reg_stop = 1'b0;
        repeat (4) step();
        chk(run == 1'b0, "R9 both from idle", run, 0);
        pulse_start(); step();
        chk(run == 1'b1, "R9 running", run, 1);
        reg_start = 1'b1; reg_stop = 1'b1; step(); reg_start = 1'b0; reg_stop = 1'b0;
        repeat (4) step();
        chk(run == 1'b0, "R9 both from run", run, 0);

        // R5: synchronized mode ignores register pulses
        mode_sel = 2'b10;
        pulse_start();
        repeat (10) step();
        chk(run == 1'b0, "R5 reg start ignored", run, 0);
        pin_start = 1'b1; step(); step();
        chk(run == 1'b1, "R12 pin rise starts", run, 1);
        pulse_stop(); step();
        chk(run == 1'b1, "R5 reg stop ignored", run, 1);
        pin_start = 1'b0; step();
        chk(run == 1'b0, "R12 pin fall stops", run, 0);

        // R6: reserved codes act as start/stop control
        mode_sel = 2'b01;
        pulse_start(); step();
        chk(run == 1'b1, "R6 mode 01 start", run, 1);
        mode_sel = 2'b11;
        pulse_stop();
        chk(run == 1'b0, "R6 mode 11 stop", run, 0);
        pulse_start(); step();
        chk(run == 1'b1, "R6 mode 11 start", run, 1);
        chk(analog_pd == 1'b0, "R10 pd low while running", analog_pd, 0);
        pulse_stop();

        // R12 in start/stop mode, R10 idle selection
        mode_sel = 2'b00;
        pin_start = 1'b1; step(); step();
        chk(run == 1'b1, "R12 pin start mode 00", run, 1);
        pin_start = 1'b0; step();
        chk(run == 1'b0, "R12 pin stop mode 00", run, 0);
        standby_sel = 1'b0; step();
        chk(analog_pd == 1'b0, "R10 idle without standby", analog_pd, 0);
        standby_sel = 1'b1; step();
        chk(analog_pd == 1'b1, "R10 idle with standby", analog_pd, 1);

        // Random phase against the model
        for (int i = 0; i < 6000; i++) begin
            int r = $urandom_range(0, 99);
            mod_tick   = ($urandom_range(0, 1) == 1);
            reg_start  = (r < 4);
            reg_stop   = (r >= 96) || (r == 50);
            if ($urandom_range(0, 99) < 2) pin_start = ~pin_start;
            if ($urandom_range(0, 199) == 0) mode_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 99) == 0) standby_sel = ~standby_sel;
            if (reg_start) delay_code = ($urandom_range(0, 9) == 0) ?
                3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
            step();
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule